// File: doc/BRIEF.md
# SPI Command Frame Shifter

This block is the serial front end of a register-mapped peripheral. While the host holds chip select low, every rising edge of the serial clock shifts one data bit into a 24-bit frame register. The bit leaving the top of that register is driven back on the serial output, so the output stream is the input stream delayed by twenty-three and a half serial clocks. When chip select returns high, the captured frame is handed to a register decoder in the system clock domain. The hand-off is a one-cycle execute strobe with the frame split into a command bit, a 7-bit address and 16 data bits.

A read takes two frames. The frame carrying the read command is executed when chip select rises. In the cycle of the strobe the decoder returns the addressed register value, and the block stores it. It then replaces the low 16 positions of the frame register with that value and leaves the upper 8 positions untouched. The host recovers the data by clocking any further frame, typically a no-op write, and watching the serial output.

The serial clock is its own clock domain. Chip select acts as an asynchronous frame boundary and crosses into the system clock through a two-flop synchronizer. The output pad is not driven here: an enable signal tells the pad ring when to drive, and the line is left floating at all other times.

Top module: `spi_frame_shifter`

## Requirements
- R1: Serial input is sampled only on a rising serial clock edge while chip select is low. Clock and data activity while chip select is high leaves the frame register unchanged.
- R2: The output enable `sdo_en` is 1 exactly while chip select is low and 0 while it is high.
- R3: Before rising edge number n of a frame (n counted from 0), `sdo` holds frame register position 23-n as it stood when the frame began, most significant first. From edge 24 onward it holds the bit shifted in 24 edges earlier. New output bits change only on falling edges.
- R4: A frame of more than 24 clocks keeps only the last 24 bits shifted in.
- R5: After chip select rises, `exec_stb` pulses within four system clock cycles. In the frame it presents, bit 23 is `exec_rd` (1 = read, 0 = write), bits 22..16 are `exec_addr` and bits 15..0 are `exec_data`.
- R6: `exec_stb` is high for exactly one system clock cycle. `exec_rd`, `exec_addr` and `exec_data` change only in a strobe cycle and hold until the next one.
- R7: On a read, `rd_data` is sampled in the strobe cycle and takes the place of frame positions 15..0, while positions 23..16 are kept. The next frame shifts this result out.
- R8: On a write, no register data is loaded, and the next frame shifts out the written frame unchanged.
- R9: A frame of fewer than 24 clocks still executes. The frame it presents is the previous register contents shifted left by the clock count, with the new bits in the low positions.
- R10: After reset the frame register is all zeros, `exec_stb` is 0, and `exec_rd`, `exec_addr` and `exec_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, asynchronous for the serial side |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select, frame boundary |
| mosi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Pad drive enable for `sdo` |
| rd_data | input | 16 | Register value returned by the decoder during a read strobe |
| exec_stb | output | 1 | One-cycle execute strobe in the system clock domain |
| exec_rd | output | 1 | Command of the executed frame, 1 = read |
| exec_addr | output | 7 | Register address of the executed frame |
| exec_data | output | 16 | Data field of the executed frame |

## Verification
The assertions assume four things about the inputs. Chip select stays high for at least eight system clock cycles between frames, so the frame register is stable when the system domain captures it. The serial clock is low whenever chip select changes. Each frame carries at least one serial clock. `rd_data` is valid in the strobe cycle. The stimulus uses a 40 ns serial clock that idles low around every chip-select edge. It waits ten system clock cycles after each frame, and it supplies `rd_data` as a fixed function of `exec_addr`. The one deliberate excursion is serial clock and data toggling with chip select high, which the block is required to ignore.

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              sdo,
  output logic              sdo_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              exec_stb,
  output logic              exec_rd,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DATA_W-1:0] exec_data
);
  localparam int FW  = 1 + ADDR_W + DATA_W;
  localparam int TOP = FW - 1;

  logic [FW-1:0]     sh;
  logic [FW-1:0]     eff;
  logic              first, launched, dout_q, out_prev;
  logic [DATA_W-1:0] ld_q;
  logic              pend;
  logic              idle_async;
  logic              cs_s1, cs_s2, cs_s3;
  logic              rise;

  assign idle_async = cs_n | rst;
  assign sdo_en     = ~cs_n;

  // pending read data merges into the low half on the first edge of a frame
  assign eff = (first && pend) ? {sh[TOP:DATA_W], ld_q} : sh;

  always_ff @(posedge sclk or posedge rst)
    if (rst) begin
      sh       <= '0;
      out_prev <= 1'b0;
    end else if (!cs_n) begin
      sh       <= {eff[TOP-1:0], mosi};
      out_prev <= eff[TOP];
    end

  always_ff @(posedge sclk or posedge idle_async)
    if (idle_async) first <= 1'b1;
    else            first <= 1'b0;

  always_ff @(negedge sclk or posedge idle_async)
    if (idle_async) begin
      launched <= 1'b0;
      dout_q   <= 1'b0;
    end else begin
      launched <= 1'b1;
      dout_q   <= sh[TOP];
    end

  assign sdo = launched ? dout_q : (first ? sh[TOP] : out_prev);

  assign rise = cs_s2 & ~cs_s3;

  always_ff @(posedge clk)
    if (rst) begin
      cs_s1     <= 1'b1;
      cs_s2     <= 1'b1;
      cs_s3     <= 1'b1;
      exec_stb  <= 1'b0;
      exec_rd   <= 1'b0;
      exec_addr <= '0;
      exec_data <= '0;
      ld_q      <= '0;
      pend      <= 1'b0;
    end else begin
      cs_s1    <= cs_n;
      cs_s2    <= cs_s1;
      cs_s3    <= cs_s2;
      exec_stb <= rise;
      if (rise) begin
        exec_rd   <= sh[TOP];
        exec_addr <= sh[TOP-1:DATA_W];
        exec_data <= sh[DATA_W-1:0];
      end
      if (exec_stb) begin
        pend <= exec_rd;
        if (exec_rd) ld_q <= rd_data;
      end
    end

  // R1
  shift_in_chk: assert property (@(posedge sclk) disable iff (rst)
    !cs_n |=> sh[0] == $past(mosi));

  // R5
  exec_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb |-> $past(cs_s2));

  // R6
  exec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> !exec_stb);

  // R6
  exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_stb |-> $stable(exec_rd) && $stable(exec_addr) && $stable(exec_data));

  // R7
  rd_load_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb && exec_rd |=> pend && ld_q == $past(rd_data));

  // R8
  wr_noload_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb && !exec_rd |=> !pend);
endmodule

// File: tb/spi_frame_shifter_tb_top.sv
module spi_frame_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        sdo, sdo_en;
  logic [15:0] rd_data;
  logic        exec_stb, exec_rd;
  logic [6:0]  exec_addr;
  logic [15:0] exec_data;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [23:0] model_sh = '0;
  logic        bit_q[$];
  string       bit_tag_q[$];
  logic [23:0] exec_q[$];
  string       exec_tag_q[$];
  event        smp_ev;

  always #4 clk = ~clk;

  function automatic logic [15:0] rd_fn(input logic [6:0] a);
    return {~a, 2'b10, a};
  endfunction

  assign rd_data = rd_fn(exec_addr);

  spi_frame_shifter dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sdo(sdo), .sdo_en(sdo_en), .rd_data(rd_data),
    .exec_stb(exec_stb), .exec_rd(exec_rd),
    .exec_addr(exec_addr), .exec_data(exec_data)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: serial output bits
  initial forever begin
    @(smp_ev);
    if (bit_q.size() == 0) chk(1'b0, "R3 no expected bit", 32'(sdo), 0);
    else begin
      logic  e;
      string t;
      e = bit_q.pop_front();
      t = bit_tag_q.pop_front();
      chk(sdo === e, t, 32'(sdo), 32'(e));
    end
  end

  // monitor: executed frames
  always @(negedge clk) if (!rst && exec_stb) begin
    if (exec_q.size() == 0) chk(1'b0, "R5 unexpected exec_stb", {8'h0, exec_rd, exec_addr, exec_data}, 0);
    else begin
      logic [23:0] e;
      string       t;
      e = exec_q.pop_front();
      t = exec_tag_q.pop_front();
      chk({exec_rd, exec_addr, exec_data} == e, t, {8'h0, exec_rd, exec_addr, exec_data}, {8'h0, e});
    end
  end

  task automatic frame(input int n, input logic [31:0] bits, input string tag);
    chk(exec_q.size() == 0, "R5 previous frame executed", exec_q.size(), 0);
    cs_n = 1'b0;
    #20;
    chk(sdo_en === 1'b1, "R2 enable while selected", 32'(sdo_en), 1);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      #18;
      bit_q.push_back(model_sh[23]);
      bit_tag_q.push_back(tag);
      -> smp_ev;
      #2 sclk = 1'b1;
      model_sh = {model_sh[22:0], bits[i]};
      #20 sclk = 1'b0;
    end
    #20 cs_n = 1'b1;
    exec_q.push_back(model_sh);
    exec_tag_q.push_back({tag, " exec"});
    if (model_sh[23]) model_sh[15:0] = rd_fn(model_sh[22:16]);
    #80;
    chk(sdo_en === 1'b0, "R2 enable after deselect", 32'(sdo_en), 0);
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chk(exec_stb === 1'b0, "R10 exec_stb reset", 32'(exec_stb), 0);
    chk({exec_rd, exec_addr, exec_data} === 24'h0, "R10 fields reset", {8'h0, exec_rd, exec_addr, exec_data}, 0);
    chk(sdo_en === 1'b0, "R10 R2 enable reset", 32'(sdo_en), 0);

    // R10 zeros out, R5 decode of write frame
    frame(24, 32'h01A5C3, "R10 R5 first write");
    // R1 R2 activity while deselected is ignored
    for (int k = 0; k < 6; k++) begin
      mosi = k[0];
      #20 sclk = 1'b1;
      chk(sdo_en === 1'b0, "R2 deselected toggling", 32'(sdo_en), 0);
      #20 sclk = 1'b0;
    end
    #80;
    // R8 R1 echo of written frame; this one is a read
    frame(24, 32'h931234, "R8 R1 echo then read");
    // R7 read data shifted out by a no-op
    frame(24, 32'h000000, "R7 read data out");
    // R4 longer frame
    frame(30, 32'h2ABCDEF1, "R4 long frame");
    // R9 short frame
    frame(10, 32'h2A5, "R9 short frame");
    // R7 read, then R9 short frame carrying loaded data
    frame(24, 32'hD5F00F, "R3 read 0x55");
    frame(12, 32'hC3A, "R9 R7 short after read");
    // R3 R8 full write and echo
    frame(24, 32'h7E8181, "R3 write");
    frame(24, 32'h00FFFF, "R3 R8 final echo");
    #200;
    chk(bit_q.size() == 0, "R3 all bits compared", bit_q.size(), 0);
    chk(exec_q.size() == 0, "R5 all frames executed", exec_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule